// File: doc/BRIEF.md
# Graphic LCD Column Driver Host Port

This block is the host-facing command and data port of a 64-column graphic LCD column driver. A host drives an 8-bit parallel bus. An enable strobe times each access, and three chip selects, a read/write line and a data/instruction line qualify it. The port decodes control instructions: display on/off, scroll start line, page select and column select. It writes and reads an external 512-byte display RAM through a page register and a wrapping column counter. It also returns a status byte.

The enable strobe is brought into the internal clock domain through a two-flop synchroniser. All writes and reads act on the falling edge of the synchronised strobe.

Read data reaches the host through a pipelined output register. The host therefore performs one dummy read after any address change. After each accepted command or data access, a busy window opens for `BUSY_CYC` internal clocks. Accesses that land in that window are dropped.

Each data access is a single registered pulse toward the RAM (write strobe or read strobe, plus the address). The RAM answers a read one clock later. There is no back-pressure on this path, because the busy window already spaces the accesses.

Top module: `glcd_host_port`

## Requirements
- R1: An access is taken only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1 at the strobe's falling edge. Otherwise no state changes and `db_oe` stays 0.
- R2: While `rst_n` is low, the following hold:
  - the display is off, and the start line, page, column and output register are 0;
  - no access is taken;
  - a status read returns bit4=1.
- R3: On a write, the byte on `db_in` when `en` falls is the byte used. Inputs must stay stable for 4 clocks after `en` falls.
- R4: `db_oe` is 1 only while `en`=1, `rw`=1 and the chip selects are valid. It is 0 at all other times.
- R5: `{di,rw}` picks the operation:
  - 11 reads display data;
  - 10 writes display data;
  - 01 reads status;
  - 00 writes an instruction.
- R6: Instruction codes are:
  - `0011111d`: display on when d=1, off when d=0;
  - `11ssssss`: start line s;
  - `10111ppp`: page p;
  - `01cccccc`: column c.
- R7: The status byte has bit7 = busy, bit5 = display off (1 = off) and bit4 = reset active. All other bits are 0.
- R8: A data read presents the output register while `en` is high. At the fall, the output register reloads from RAM address {page,column}. The first read after an address set therefore returns stale data.
- R9: Each data write or read increments the column, wrapping from 63 to 0. The page never counts. The RAM address is {page[2:0],column[5:0]}.
- R10: An accepted non-status access holds busy for `BUSY_CYC` clocks (default 2). A falling edge taken while busy changes nothing.
- R11: Page and column instructions leave the output register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| en | input | 1 | Bus strobe (asynchronous) |
| rw | input | 1 | 1 = read, 0 = write |
| di | input | 1 | 1 = display data, 0 = instruction/status |
| db_in | input | 8 | Bus data from host |
| db_out | output | 8 | Bus data to host |
| db_oe | output | 1 | Bus output enable |
| ram_addr | output | 9 | RAM address {page,column} |
| ram_we | output | 1 | RAM write pulse |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read pulse |
| ram_rdata | input | 8 | RAM read data, valid one clock after `ram_re` |
| disp_on | output | 1 | Display enabled |
| start_line | output | 6 | Scroll start line |

## Verification
Two things can coincide in one clock cycle: the falling edge of a new access, and the busy window still left over from the previous access.

The bench provokes this by strobing a second instruction only two clocks after the first one is taken. The first instruction turns the display on, and the second would turn it off again. The outcome is judged through the status byte and `disp_on`: the display must remain on.

A second overlap is the address-set instruction versus the pipelined output register. A read issued right after a page/column change must still return the byte fetched by the preceding read.

// File: rtl/glcd_pkg.sv
package glcd_pkg;
  localparam int DATA_W = 8;
  localparam int COL_W  = 6;
  localparam int PAGE_W = 3;
  localparam int ADDR_W = PAGE_W + COL_W;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_DISP,
    CMD_LINE,
    CMD_PAGE,
    CMD_COL
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e        kind;
    logic [COL_W-1:0] arg;
  } cmd_t;

  // {di,rw} operation codes
  localparam logic [1:0] OP_INSTR  = 2'b00;
  localparam logic [1:0] OP_STATUS = 2'b01;
  localparam logic [1:0] OP_DWRITE = 2'b10;
  localparam logic [1:0] OP_DREAD  = 2'b11;
endpackage

// File: rtl/glcd_strobe_sync.sv
module glcd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall = last_q & ~sync_q[STAGES-1];

  // R3: one falling edge gives exactly one event
  a_r3_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/glcd_cmd_decode.sv
module glcd_cmd_decode
  import glcd_pkg::*;
(
  input  logic [DATA_W-1:0] code,
  output cmd_t              cmd
);
  always_comb begin
    cmd.kind = CMD_NONE;
    cmd.arg  = code[COL_W-1:0];
    if (code[7:6] == 2'b11)
      cmd.kind = CMD_LINE;
    else if (code[7:6] == 2'b01)
      cmd.kind = CMD_COL;
    else if (code[7:3] == 5'b10111)
      cmd.kind = CMD_PAGE;
    else if (code[7:1] == 7'b0011111)
      cmd.kind = CMD_DISP;
  end
endmodule

// File: rtl/glcd_busy_timer.sv
module glcd_busy_timer #(
  parameter int BUSY_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (start)
      cnt_q <= CNT_W'(BUSY_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R10: a started operation is visible as busy on the next cycle
  a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/glcd_host_port.sv
module glcd_host_port
  import glcd_pkg::*;
#(
  parameter int BUSY_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic              cs3,
  input  logic              en,
  input  logic              rw,
  input  logic              di,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_out,
  output logic              db_oe,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_re,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              disp_on,
  output logic [COL_W-1:0]  start_line
);
  logic              fall, busy, cs_ok, take, busy_start, rd_pend_q;
  logic [1:0]        op;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] out_q, status;
  cmd_t              cmd;

  glcd_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe(en), .fall(fall));

  glcd_cmd_decode u_dec (.code(db_in), .cmd(cmd));

  glcd_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(busy));

  assign cs_ok      = ~cs1_n & ~cs2_n & cs3;
  assign op         = {di, rw};
  assign take       = fall & cs_ok & ~busy;
  assign busy_start = take & (op != OP_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      col_q      <= '0;
      disp_on    <= 1'b0;
      start_line <= '0;
      ram_addr   <= '0;
      ram_we     <= 1'b0;
      ram_re     <= 1'b0;
      ram_wdata  <= '0;
      rd_pend_q  <= 1'b0;
      out_q      <= '0;
    end else begin
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      rd_pend_q <= ram_re;
      if (rd_pend_q)
        out_q <= ram_rdata;
      if (take) begin
        unique case (op)
          OP_DREAD: begin
            ram_re   <= 1'b1;
            ram_addr <= {page_q, col_q};
            col_q    <= col_q + 1'b1;
          end
          OP_DWRITE: begin
            ram_we    <= 1'b1;
            ram_wdata <= db_in;
            ram_addr  <= {page_q, col_q};
            col_q     <= col_q + 1'b1;
          end
          OP_INSTR: begin
            unique case (cmd.kind)
              CMD_DISP: disp_on    <= cmd.arg[0];
              CMD_LINE: start_line <= cmd.arg;
              CMD_PAGE: page_q     <= cmd.arg[PAGE_W-1:0];
              CMD_COL:  col_q      <= cmd.arg;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  assign status = {busy, 1'b0, ~disp_on, ~rst_n, 4'b0000};
  assign db_out = di ? out_q : status;
  assign db_oe  = cs_ok & rw & en;

  // R1: every RAM access traces back to a selected strobe
  a_r1_selected_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> $past(cs_ok));

  // R9: the issued address is the pre-increment column on the unchanged page
  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> (col_q == ram_addr[COL_W-1:0] + 1'b1) &&
                           (page_q == ram_addr[ADDR_W-1:COL_W]));

  // R10: a RAM access always sits inside a busy window
  a_r10_access_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |-> busy);

  // R2: reset defaults hold while reset is asserted
  always @(posedge clk)
    if (!rst_n)
      a_r2_reset_defaults: assert (!disp_on && start_line == '0 && !ram_we);
endmodule

// File: tb/glcd_host_port_bench.sv
module glcd_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n, cs1_n, cs2_n, cs3, en, rw, di;
  logic [7:0] db_in, db_out, ram_wdata, ram_rdata;
  logic       db_oe, ram_we, ram_re, disp_on;
  logic [8:0] ram_addr;
  logic [5:0] start_line;
  logic [7:0] mem [512];
  int checks = 0, fails = 0;
  logic [7:0] q;

  always #5 clk = ~clk;

  glcd_host_port u_glcd_host_port (
    .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3),
    .en(en), .rw(rw), .di(di), .db_in(db_in), .db_out(db_out),
    .db_oe(db_oe), .ram_addr(ram_addr), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_re(ram_re), .ram_rdata(ram_rdata),
    .disp_on(disp_on), .start_line(start_line));

  // external RAM model, one-clock read latency
  initial for (int i = 0; i < 512; i++) mem[i] = 8'h00;
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic bus(input logic [1:0] op, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    di = op[1]; rw = op[0]; db_in = d;
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (3) @(negedge clk);
    r = db_out;
    en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // op[17:16]={di,rw}, data[15:8], expected[7:0] (checked when rw=1)
  localparam logic [17:0] TBL [14] = '{
    {2'b00, 8'h3F, 8'h00},  // display on
    {2'b00, 8'hBA, 8'h00},  // page 2
    {2'b00, 8'h7E, 8'h00},  // column 62
    {2'b10, 8'hA5, 8'h00},  // write (2,62)
    {2'b10, 8'h5A, 8'h00},  // write (2,63)
    {2'b10, 8'hC3, 8'h00},  // write (2,0) after wrap
    {2'b00, 8'h7E, 8'h00},  // column 62
    {2'b11, 8'h00, 8'h00},  // dummy read: reset value
    {2'b11, 8'h00, 8'hA5},
    {2'b11, 8'h00, 8'h5A},
    {2'b11, 8'h00, 8'hC3},  // wrapped column, page unchanged
    {2'b01, 8'h00, 8'h00},  // status: on, ready
    {2'b00, 8'h3E, 8'h00},  // display off
    {2'b01, 8'h00, 8'h20}   // status: off
  };

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; cs1_n = 1'b0; cs2_n = 1'b0; cs3 = 1'b1;
    en = 1'b0; rw = 1'b1; di = 1'b0; db_in = 8'h00;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R2 status in reset", db_out, 8'h30);
    chk("R4 oe on status read", {7'b0, db_oe}, 8'h01);
    chk("R2 display off", {7'b0, disp_on}, 8'h00);
    chk("R2 start line", {2'b0, start_line}, 8'h00);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus(2'b01, 8'h00, q);
    chk("R7 status after reset", q, 8'h20);

    // R5 R6 R8 R9: vector table
    for (int i = 0; i < 14; i++) begin
      bus(TBL[i][17:16], TBL[i][15:8], q);
      if (TBL[i][16]) chk($sformatf("R8/R9 vector %0d", i), q, TBL[i][7:0]);
    end

    // R6 start line codes
    bus(2'b00, 8'hC5, q);
    chk("R6 start line 5", {2'b0, start_line}, 8'h05);
    bus(2'b00, 8'hFF, q);
    chk("R6 start line 63", {2'b0, start_line}, 8'h3F);

    // R1 unselected access is ignored
    cs3 = 1'b0;
    bus(2'b00, 8'h3F, q);
    chk("R1 ignored on/off", {7'b0, disp_on}, 8'h00);
    @(negedge clk); rw = 1'b1; di = 1'b0; en = 1'b1;
    @(negedge clk);
    chk("R1 R4 no bus drive", {7'b0, db_oe}, 8'h00);
    en = 1'b0; cs3 = 1'b1;
    repeat (6) @(negedge clk);

    // R11 address set keeps output register
    bus(2'b00, 8'hBA, q);
    bus(2'b00, 8'h7E, q);
    bus(2'b11, 8'h00, q);
    bus(2'b11, 8'h00, q);
    chk("R8 read after dummy", q, 8'hA5);
    bus(2'b00, 8'hBD, q);
    bus(2'b00, 8'h40, q);
    bus(2'b11, 8'h00, q);
    chk("R11 stale after address set", q, 8'h5A);

    // R3 byte present at the fall is captured
    bus(2'b00, 8'h45, q);  // column 5, page 5
    @(negedge clk); di = 1'b1; rw = 1'b0; db_in = 8'h11;
    @(negedge clk); en = 1'b1;
    @(negedge clk); db_in = 8'h77;
    @(negedge clk); en = 1'b0;
    repeat (8) @(negedge clk);
    bus(2'b00, 8'h45, q);
    bus(2'b11, 8'h00, q);
    bus(2'b11, 8'h00, q);
    chk("R3 capture at fall", q, 8'h77);

    // R10 second strobe lands inside busy window
    @(negedge clk); di = 1'b0; rw = 1'b0; db_in = 8'h3F; en = 1'b1;
    repeat (4) @(negedge clk);
    en = 1'b0;               // first fall
    @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0; // second fall
    @(negedge clk); db_in = 8'h3E;
    repeat (8) @(negedge clk);
    chk("R10 busy drop", {7'b0, disp_on}, 8'h01);
    bus(2'b01, 8'h00, q);
    chk("R10 R7 status on", q, 8'h00);

    summary();
  end
endmodule